// File: doc/BRIEF.md
# Start-Sequence-Triggered Serial Symbol Receiver

This block takes one data-sliced serial line from a radio receiver and oversamples it with the system clock. It waits for a distinctive start sequence before it decodes anything. That sequence is a long steady high level followed by a short run of alternating bits. When the sequence is recognised, the block raises a sticky start flag that can wake a sleeping host. The alternating bits are used to lock the bit-sampling phase to the line's edges.

After the start flag rises, every following bit is sampled in the middle of its bit period and reported with a one-cycle strobe. The bits are packed most-significant-first into 12-bit symbols, and a ready flag tells the host that a symbol can be read. Framing is continuous: there are no start or stop bits per symbol, and the block never detects the end of a message by itself. Symbols keep coming until the host drops the start flag with a clear input. While data flows, edges on the line pull the sampling phase toward its nominal position, so a transmitter running slightly fast or slow is still sampled correctly.

Top module: `sym_rx`

## Requirements
- R1: After a synchronous reset, start_det, bit_stb, bit_val, sym_rdy, overrun and sym_data are all zero.
- R2: The start sequence is a high run lasting LEAD_BITS+1 bit periods (LEAD_BITS steady highs plus the first, high, training bit), followed by TRAIN_BITS-1 single bits low, high, low, … ending low. start_det rises during that final low training bit, and not before its middle.
- R3: start_det stays high until start_clr is seen high on a clock edge. start_clr clears start_det, sym_rdy and overrun, and no bit strobes or symbols appear afterwards until a new start sequence is found.
- R4: A high run is accepted only if it lasts between (LEAD_BITS+1)·BIT_CLKS − BIT_CLKS/2 and (LEAD_BITS+1)·BIT_CLKS + BIT_CLKS/2 clock cycles. This is 340 to 380 cycles with the defaults. A shorter or longer run restarts the search.
- R5: A training bit that does not continue the alternating pattern restarts the search, and start_det stays low.
- R6: Once start_det is high, each bit is sampled BIT_CLKS/2 cycles after the phase reference, which is the middle of the bit. For each bit, bit_stb is high for exactly one cycle, with bit_val holding the sampled level. Every symbol produces exactly SYM_BITS strobes.
- R7: The first bit after the last training bit becomes bit SYM_BITS-1 (the MSB) of the first symbol, and bits arrive MSB first. When the SYM_BITS-th bit is sampled, sym_rdy goes high and sym_data holds the whole symbol.
- R8: A one-cycle sym_rd pulse clears sym_rdy.
- R9: If a symbol completes while sym_rdy is still high and unread, sym_data is replaced by the new symbol, sym_rdy stays high, and overrun goes high. overrun stays high until start_clr.
- R10: Symbols are received correctly when the bit period differs from BIT_CLKS by up to ±1%. Each line edge seen during data moves the phase counter one cycle toward its nominal edge position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (BIT_CLKS cycles per bit) |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Sliced serial data from the radio, asynchronous |
| start_clr | input | 1 | Host clear of the start flag and of receive state |
| sym_rd | input | 1 | One-cycle host read strobe for the held symbol |
| start_det | output | 1 | Sticky start-sequence-found flag |
| bit_stb | output | 1 | One-cycle strobe for each sampled data bit |
| bit_val | output | 1 | Level of the bit qualified by bit_stb |
| sym_data | output | SYM_BITS | Last completed symbol, MSB received first |
| sym_rdy | output | 1 | A completed symbol is waiting to be read |
| overrun | output | 1 | A symbol was replaced before it was read |

## Verification
The bench sends high runs that are just under the accepted length and far over it, and a training pattern with a repeated bit. A hunter with loose windows or no alternation check would raise start_det on these false sequences. It checks that start_det is still low one training bit before the end, which catches a design that fires early or counts training bits wrongly. It sends back-to-back random symbols, first unread and then after a clear. A design with the wrong bit order or bit count would show a wrong sym_data or strobe count. A design that keeps running after start_clr would emit strobes. Finally, it streams symbols with bit periods 1% long and 1% short. A design without edge tracking would slip a bit within a few symbols.

// File: rtl/sym_rx_pkg.sv
package sym_rx_pkg;

    // Default geometry of the receiver.
    localparam int BIT_CLKS_DEF   = 40;
    localparam int SYM_BITS_DEF   = 12;
    localparam int LEAD_BITS_DEF  = 8;
    localparam int TRAIN_BITS_DEF = 8;

    // Phases of the start-sequence search.
    typedef enum logic [1:0] {
        HS_IDLE,
        HS_HIGH,
        HS_TRAIN,
        HS_DATA
    } hunt_state_e;

    // Synchronised line level and its transitions.
    typedef struct packed {
        logic lvl;
        logic flip;
        logic rise;
        logic fall;
    } line_t;

    // One sampled data bit.
    typedef struct packed {
        logic stb;
        logic val;
    } samp_t;

    function automatic bit in_window(int unsigned v, int unsigned lo, int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic int unsigned wrap_add(int unsigned v, int unsigned d, int unsigned m);
        int unsigned t;
        t = v + d;
        if (t >= m) t = t - m;
        return t;
    endfunction

endpackage

// File: rtl/sym_rx_sync.sv
module sym_rx_sync
    import sym_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_i,
    output line_t line_o
);

    logic meta_q, lvl_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= rx_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    always_comb begin
        line_o.lvl  = lvl_q;
        line_o.flip = lvl_q ^ prev_q;
        line_o.rise = lvl_q & ~prev_q;
        line_o.fall = ~lvl_q & prev_q;
    end

endmodule

// File: rtl/sym_rx_phase.sv
module sym_rx_phase
    import sym_rx_pkg::*;
#(
    parameter int BIT_CLKS = BIT_CLKS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic flip_i,
    input  logic hard_i,
    output logic mid_o
);

    localparam int PW   = $clog2(BIT_CLKS);
    localparam int HALF = BIT_CLKS / 2;

    logic [PW-1:0] ph_q, ph_n;

    always_comb begin
        if (ph_q == PW'(BIT_CLKS - 1)) ph_n = '0;
        else                           ph_n = ph_q + 1'b1;
        if (flip_i) begin
            if (hard_i) begin
                // edge cycle is phase zero
                ph_n = PW'(1);
            end else if (ph_q != '0 && ph_q < PW'(HALF)) begin
                // edge came late: stall one cycle
                ph_n = ph_q;
            end else if (ph_q > PW'(HALF)) begin
                // edge came early: skip one cycle
                ph_n = PW'(wrap_add(32'(ph_q), 2, BIT_CLKS));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_n;
    end

    assign mid_o = (ph_q == PW'(HALF));

    assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
        32'(ph_q) < BIT_CLKS);

    assert_mid_single_R6: assert property (@(posedge clk) disable iff (rst)
        mid_o |=> !mid_o);

endmodule

// File: rtl/sym_rx_hunt.sv
module sym_rx_hunt
    import sym_rx_pkg::*;
#(
    parameter int BIT_CLKS   = BIT_CLKS_DEF,
    parameter int LEAD_BITS  = LEAD_BITS_DEF,
    parameter int TRAIN_BITS = TRAIN_BITS_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t line_i,
    input  logic  mid_i,
    input  logic  clr_i,
    output logic  start_o,
    output logic  hard_o,
    output samp_t samp_o
);

    localparam int RUN_NOM = (LEAD_BITS + 1) * BIT_CLKS;
    localparam int RUN_LO  = RUN_NOM - BIT_CLKS / 2;
    localparam int RUN_HI  = RUN_NOM + BIT_CLKS / 2;
    localparam int HW      = $clog2(RUN_HI + 2);
    localparam int TW      = $clog2(TRAIN_BITS);
    localparam int LAST_T  = TRAIN_BITS - 2;

    hunt_state_e   st;
    logic [HW-1:0] hcnt;
    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            st      <= HS_IDLE;
            hcnt    <= '0;
            tcnt    <= '0;
            start_o <= 1'b0;
            samp_o  <= '0;
        end else begin
            samp_o <= '0;
            case (st)
                HS_IDLE: begin
                    if (line_i.rise) begin
                        st   <= HS_HIGH;
                        hcnt <= HW'(1);
                    end
                end
                HS_HIGH: begin
                    if (line_i.fall) begin
                        if (in_window(32'(hcnt), RUN_LO, RUN_HI)) begin
                            st   <= HS_TRAIN;
                            tcnt <= '0;
                        end else begin
                            st <= HS_IDLE;
                        end
                    end else if (hcnt <= HW'(RUN_HI)) begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                HS_TRAIN: begin
                    if (mid_i) begin
                        // even training slots are low, odd ones high
                        if (line_i.lvl == tcnt[0]) begin
                            if (tcnt == TW'(LAST_T)) begin
                                st      <= HS_DATA;
                                start_o <= 1'b1;
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end else begin
                            st <= HS_IDLE;
                        end
                    end
                end
                default: begin
                    samp_o.stb <= mid_i;
                    samp_o.val <= line_i.lvl;
                end
            endcase
        end
    end

    assign hard_o = (st != HS_DATA);

    assert_det_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        start_o && !clr_i |=> start_o);

    assert_clr_drops_R3: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !start_o && !samp_o.stb);

    assert_det_after_train_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(start_o) |-> $past(st == HS_TRAIN && mid_i));

    assert_stb_gated_R6: assert property (@(posedge clk) disable iff (rst)
        samp_o.stb |-> start_o);

endmodule

// File: rtl/sym_rx_asm.sv
module sym_rx_asm
    import sym_rx_pkg::*;
#(
    parameter int SYM_BITS = SYM_BITS_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  samp_t               samp_i,
    input  logic                rd_i,
    input  logic                clr_i,
    output logic [SYM_BITS-1:0] data_o,
    output logic                rdy_o,
    output logic                ovr_o
);

    localparam int CW = $clog2(SYM_BITS);

    logic [SYM_BITS-2:0] sh_q;
    logic [CW-1:0]       bcnt;
    logic                done;

    assign done = samp_i.stb && (bcnt == CW'(SYM_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sh_q   <= '0;
            bcnt   <= '0;
            data_o <= '0;
            rdy_o  <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            if (samp_i.stb) begin
                if (done) begin
                    data_o <= {sh_q, samp_i.val};
                    bcnt   <= '0;
                end else begin
                    sh_q <= {sh_q[SYM_BITS-3:0], samp_i.val};
                    bcnt <= bcnt + 1'b1;
                end
            end
            if (done) begin
                rdy_o <= 1'b1;
                if (rdy_o && !rd_i) ovr_o <= 1'b1;
            end else if (rd_i) begin
                rdy_o <= 1'b0;
            end
        end
    end

    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
        32'(bcnt) < SYM_BITS);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rd_i && !done && !clr_i |=> !rdy_o);

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (rst)
        done && rdy_o && !rd_i && !clr_i |=> ovr_o && rdy_o);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ovr_o && !clr_i |=> ovr_o);

endmodule

// File: rtl/sym_rx.sv
module sym_rx
    import sym_rx_pkg::*;
#(
    parameter int BIT_CLKS   = BIT_CLKS_DEF,
    parameter int SYM_BITS   = SYM_BITS_DEF,
    parameter int LEAD_BITS  = LEAD_BITS_DEF,
    parameter int TRAIN_BITS = TRAIN_BITS_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_in,
    input  logic                start_clr,
    input  logic                sym_rd,
    output logic                start_det,
    output logic                bit_stb,
    output logic                bit_val,
    output logic [SYM_BITS-1:0] sym_data,
    output logic                sym_rdy,
    output logic                overrun
);

    line_t line;
    logic  mid, hard;
    samp_t samp;

    sym_rx_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .rx_i   (rx_in),
        .line_o (line)
    );

    sym_rx_phase #(.BIT_CLKS(BIT_CLKS)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .flip_i (line.flip),
        .hard_i (hard),
        .mid_o  (mid)
    );

    sym_rx_hunt #(
        .BIT_CLKS   (BIT_CLKS),
        .LEAD_BITS  (LEAD_BITS),
        .TRAIN_BITS (TRAIN_BITS)
    ) u_hunt (
        .clk     (clk),
        .rst     (rst),
        .line_i  (line),
        .mid_i   (mid),
        .clr_i   (start_clr),
        .start_o (start_det),
        .hard_o  (hard),
        .samp_o  (samp)
    );

    sym_rx_asm #(.SYM_BITS(SYM_BITS)) u_asm (
        .clk    (clk),
        .rst    (rst),
        .samp_i (samp),
        .rd_i   (sym_rd),
        .clr_i  (start_clr),
        .data_o (sym_data),
        .rdy_o  (sym_rdy),
        .ovr_o  (overrun)
    );

    assign bit_stb = samp.stb;
    assign bit_val = samp.val;

    assert_rdy_under_det_R3: assert property (@(posedge clk) disable iff (rst)
        sym_rdy |-> start_det);

endmodule

// File: tb/sym_rx_test.sv
module sym_rx_test;
    import sym_rx_pkg::*;

    localparam int BITC  = 40;
    localparam int SYMW  = 12;
    localparam int LEAD  = 8;
    localparam int TRAIN = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rx_in = 1'b0;
    logic            start_clr = 1'b0;
    logic            sym_rd = 1'b0;
    logic            start_det, bit_stb, bit_val, sym_rdy, overrun;
    logic [SYMW-1:0] sym_data;

    sym_rx uut (
        .clk       (clk),
        .rst       (rst),
        .rx_in     (rx_in),
        .start_clr (start_clr),
        .sym_rd    (sym_rd),
        .start_det (start_det),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .sym_data  (sym_data),
        .sym_rdy   (sym_rdy),
        .overrun   (overrun)
    );

    always #10 clk = ~clk;

    int        checks = 0;
    int        fails = 0;
    bit        finished = 0;
    int        drift = 0;      // tenths of a clock added per bit
    int        acc = 0;
    bit        rd_req = 0;
    bit        clr_req = 0;
    int        stb_cnt = 0;
    logic [SYMW-1:0] mon_sh = '0;

    always @(negedge clk) begin
        if (!rst && bit_stb) begin
            stb_cnt++;
            mon_sh = {mon_sh[SYMW-2:0], bit_val};
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(logic v);
        int len;
        len = BITC;
        acc += drift;
        if (acc >= 10) begin
            len++;
            acc -= 10;
        end else if (acc <= -10) begin
            len--;
            acc += 10;
        end
        rx_in = v;
        sym_rd = rd_req;
        start_clr = clr_req;
        rd_req = 0;
        clr_req = 0;
        @(negedge clk);
        sym_rd = 1'b0;
        start_clr = 1'b0;
        repeat (len - 1) @(negedge clk);
    endtask

    task automatic send_run(logic v, int n);
        for (int i = 0; i < n; i++) send_bit(v);
    endtask

    task automatic send_cycles(logic v, int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    // training bits after the merged high bit: low, high, ... ending low
    task automatic send_train();
        for (int i = 1; i < TRAIN; i++) send_bit(i % 2 == 0);
    endtask

    task automatic send_preamble(int hi_adj);
        send_cycles(1'b1, (LEAD + 1) * BITC + hi_adj);
        for (int i = 1; i < TRAIN - 1; i++) send_bit(i % 2 == 0);
        check("R2", "start_det before last training bit", 32'(start_det), 0);
        send_bit(1'b0);
        check("R2", "start_det after training", 32'(start_det), 1);
    endtask

    task automatic rx_sym(logic [SYMW-1:0] w, bit chk_read);
        stb_cnt = 0;
        for (int i = SYMW - 1; i >= 0; i--) begin
            send_bit(w[i]);
            if (chk_read && i == SYMW - 1)
                check("R8", "sym_rdy after read strobe", 32'(sym_rdy), 0);
        end
        check("R7", "sym_rdy at symbol end", 32'(sym_rdy), 1);
        check("R7", "sym_data", 32'(sym_data), 32'(w));
        check("R6", "strobes per symbol", 32'(stb_cnt), SYMW);
        check("R6", "strobed bit values", 32'(mon_sh), 32'(w));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        logic [SYMW-1:0] w, w2;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1", "start_det", 32'(start_det), 0);
        check("R1", "bit_stb", 32'(bit_stb), 0);
        check("R1", "sym_rdy", 32'(sym_rdy), 0);
        check("R1", "overrun", 32'(overrun), 0);
        check("R1", "sym_data", 32'(sym_data), 0);
        send_run(1'b0, 4);

        // R4: short high run
        send_cycles(1'b1, 5 * BITC);
        send_train();
        send_run(1'b0, 4);
        check("R4", "short high run ignored", 32'(start_det), 0);

        // R4: high run just below the window
        send_cycles(1'b1, (LEAD + 1) * BITC - BITC / 2 - 5);
        send_train();
        send_run(1'b0, 4);
        check("R4", "high run below window ignored", 32'(start_det), 0);

        // R4: long high run
        send_cycles(1'b1, 14 * BITC);
        send_train();
        send_run(1'b0, 4);
        check("R4", "long high run ignored", 32'(start_det), 0);

        // R5: broken alternation
        send_cycles(1'b1, (LEAD + 1) * BITC);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        send_run(1'b0, 4);
        check("R5", "broken training ignored", 32'(start_det), 0);

        // R2: valid start, high run slightly short but in window
        send_preamble(-15);

        // R6/R7/R8: back-to-back random symbols, each read
        for (int k = 0; k < 8; k++) begin
            w = SYMW'($urandom);
            rx_sym(w, k != 0);
            rd_req = 1;
        end

        // R9: two symbols without a read
        w = SYMW'($urandom);
        rx_sym(w, 1);
        check("R9", "no overrun after read stream", 32'(overrun), 0);
        w2 = SYMW'($urandom);
        rx_sym(w2, 0);
        check("R9", "overrun on unread symbol", 32'(overrun), 1);
        check("R9", "data replaced", 32'(sym_data), 32'(w2));
        check("R3", "start_det sticky during data", 32'(start_det), 1);

        // R3: clear, then more line activity
        clr_req = 1;
        send_bit(1'b1);
        check("R3", "start_det cleared", 32'(start_det), 0);
        check("R3", "sym_rdy cleared", 32'(sym_rdy), 0);
        check("R3", "overrun cleared", 32'(overrun), 0);
        stb_cnt = 0;
        send_run(1'b0, 1);
        w = SYMW'($urandom);
        for (int i = SYMW - 1; i >= 0; i--) send_bit(w[i]);
        check("R3", "no strobes after clear", 32'(stb_cnt), 0);
        check("R3", "no symbol after clear", 32'(sym_rdy), 0);
        send_run(1'b0, 4);

        // R10: transmitter 1% slow
        drift = 4;
        acc = 0;
        send_preamble(0);
        for (int k = 0; k < 6; k++) begin
            w = SYMW'($urandom);
            rx_sym(w, k != 0);
            rd_req = 1;
        end
        check("R10", "slow stream start_det", 32'(start_det), 1);
        clr_req = 1;
        send_run(1'b0, 4);

        // R10: transmitter 1% fast
        drift = -4;
        acc = 0;
        send_preamble(0);
        for (int k = 0; k < 6; k++) begin
            w = SYMW'($urandom);
            rx_sym(w, k != 0);
            rd_req = 1;
        end
        check("R10", "fast stream overrun", 32'(overrun), 0);
        send_run(1'b0, 2);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule